// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block tracks lock reservations for load-linked / store-conditional pairs and for locked read-modify-write sequences. It sits next to a data cache lookup. Each completed access arrives as one event carrying an operation code, a line address, a requester ID and a flag saying whether the line is resident in the cache. The monitor answers every completion one cycle later with a result bit. For a store-conditional this bit says whether it succeeded. Locked read-modify-write completions also produce a one-cycle pulse that stalls or releases the request queue of that line.

A separate invalidation port reports loss of coherence permission on a line, together with the requester whose lock must be dropped. The table holds a parameterised number of reservations. A load-linked that finds the table full evicts the reservation that was set or refreshed longest ago. A configuration input turns the whole reservation mechanism off, and every operation then reports success.

Top module: `llsc_resv_mon`

## Requirements
- R1: After reset the table holds no reservations, and `res_valid`, `q_block` and `q_unblock` are low.
- R2: Every completion accepted in cycle N gives `res_valid` high in cycle N+1, with `res_line` equal to its line. Any operation other than store-conditional (op 3) reports `res_ok` = 1.
- R3: A resident load-linked (op 2) sets a reservation on its line owned by its requester. A later store-conditional on that line by the same requester reports `res_ok` = 1.
- R4: A store-conditional reports `res_ok` = 0 when the line has no reservation, or when the reservation belongs to another requester.
- R5: Every resident store-conditional removes the reservation on its line, whoever owns it and whatever its result.
- R6: A resident store (op 1), locked read (op 4), locked write (op 5) or flush (op 6) removes a reservation on its line only if the reservation belongs to the same requester. Such a write from a different requester leaves the reservation in place.
- R7: A load (op 0) or instruction fetch (op 7) never changes any reservation.
- R8: A completion with `cmp_present` low reports `res_ok` = 1 and changes no reservation.
- R9: An invalidation removes the reservation on `inv_line` only if the reservation belongs to `inv_req`. If it arrives in the same cycle as a completion, the invalidation takes effect first.
- R10: A locked read (op 4) completion raises `q_block`, and a locked write (op 5) completion raises `q_unblock`. Each pulse lasts one cycle, in the cycle after the completion, and appears whether or not the line is resident or the bypass is set.
- R11: While `cfg_bypass` is high every completion reports `res_ok` = 1, and neither completions nor invalidations change any reservation.
- R12: A load-linked to a line that already holds a reservation hands that reservation to the new requester and does not take a second entry.
- R13: A load-linked that finds all entries in use replaces the entry whose reservation was set or refreshed earliest. A refresh by a load-linked makes an entry the newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | Disables reservation handling; all results succeed |
| cmp_valid | input | 1 | A completion is presented this cycle |
| cmp_op | input | 3 | Operation code (0 load, 1 store, 2 load-linked, 3 store-conditional, 4 locked read, 5 locked write, 6 flush, 7 fetch) |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_req | input | ID_W | Requester ID of the completion |
| cmp_present | input | 1 | The line is resident in the data cache |
| inv_valid | input | 1 | Permission on a line was lost this cycle |
| inv_line | input | LINE_W | Line that lost permission |
| inv_req | input | ID_W | Requester whose lock on that line is dropped |
| res_valid | output | 1 | Result of last cycle's completion is presented |
| res_ok | output | 1 | Success bit of that completion |
| res_line | output | LINE_W | Line of that completion |
| q_block | output | 1 | Stall the request queue of `res_line` |
| q_unblock | output | 1 | Release the request queue of `res_line` |

## Verification
A wrong internal state shows up only through a later store-conditional. A reservation that was dropped by mistake makes the next store-conditional by the owner report 0, and a reservation that should have been cleared makes it report 1, exactly one cycle after that store-conditional is presented. The bench therefore follows each state-changing event with a probing store-conditional, so a bad clear, a bad set or a bad eviction choice is seen within a few cycles. An error in the age ordering shows up only once the table is full and refilled, so one sequence fills it, frees an entry, refreshes another and evicts again.

// File: rtl/llsc_mon_pkg.sv
package llsc_mon_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LL    = 3'd2,
    OP_SC    = 3'd3,
    OP_LRD   = 3'd4,
    OP_LWR   = 3'd5,
    OP_FLUSH = 3'd6,
    OP_FETCH = 3'd7
  } llsc_op_e;
endpackage

// File: rtl/llsc_op_decode.sv
module llsc_op_decode
  import llsc_mon_pkg::*;
(
  input  logic [2:0] op,
  output logic       is_ll,
  output logic       is_sc,
  output logic       is_wr,
  output logic       is_lrd,
  output logic       is_lwr
);
  llsc_op_e op_e;

  always_comb begin
    op_e   = llsc_op_e'(op);
    is_ll  = (op_e == OP_LL);
    is_sc  = (op_e == OP_SC);
    is_lrd = (op_e == OP_LRD);
    is_lwr = (op_e == OP_LWR);
    // write-class operations that drop the requester's own lock (R6)
    is_wr  = (op_e == OP_STORE) || (op_e == OP_LRD) ||
             (op_e == OP_LWR)   || (op_e == OP_FLUSH);
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int N      = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_en,
  input  logic [LINE_W-1:0] inv_line,
  input  logic [ID_W-1:0]   inv_req,
  input  logic              op_en,
  input  logic              op_ll,
  input  logic              op_sc,
  input  logic              op_wr,
  input  logic [LINE_W-1:0] op_line,
  input  logic [ID_W-1:0]   op_req,
  output logic              sc_hit
);
  localparam int RK_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      vld_q, vld_d;
  logic [LINE_W-1:0] line_q [N];
  logic [ID_W-1:0]   own_q  [N];
  logic [RK_W-1:0]   rank_q [N];
  logic [RK_W-1:0]   rank_d [N];

  logic [N-1:0] inv_clr, vld_eff, ln_hit, own_hit;
  logic [N-1:0] free_oh, vict_oh, tgt_oh, cmp_clr, gone;
  logic         alloc, free_found;

  // per-entry match logic
  for (genvar g = 0; g < N; g++) begin : g_match
    assign inv_clr[g] = inv_en && vld_q[g] && (line_q[g] == inv_line) &&
                        (own_q[g] == inv_req);
    assign vld_eff[g] = vld_q[g] && !inv_clr[g];
    assign ln_hit[g]  = vld_eff[g] && (line_q[g] == op_line);
    assign own_hit[g] = ln_hit[g] && (own_q[g] == op_req);
  end

  assign sc_hit = |own_hit;
  assign alloc  = op_en && op_ll;

  // slot choice for a load-linked: same line, else first free, else oldest
  always_comb begin
    free_oh    = '0;
    vict_oh    = '0;
    free_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!vld_eff[i] && !free_found) begin
        free_oh[i] = 1'b1;
        free_found = 1'b1;
      end
      if (vld_eff[i] && (rank_q[i] == RK_W'(N - 1))) vict_oh[i] = 1'b1;
    end
    if (|ln_hit)       tgt_oh = ln_hit;
    else if (|free_oh) tgt_oh = free_oh;
    else               tgt_oh = vict_oh;
  end

  always_comb begin
    cmp_clr = '0;
    if (op_en) begin
      if (op_sc)      cmp_clr = ln_hit;
      else if (op_wr) cmp_clr = own_hit;
      else if (op_ll) cmp_clr = tgt_oh & vld_eff;
    end
    gone = inv_clr | cmp_clr;
  end

  // age ranks: compact over removed entries, push survivors back on allocation
  always_comb begin
    for (int i = 0; i < N; i++) begin
      int cnt;
      int r;
      cnt = 0;
      for (int j = 0; j < N; j++) begin
        if (gone[j] && (rank_q[j] < rank_q[i])) cnt++;
      end
      r = int'(rank_q[i]) - cnt + (alloc ? 1 : 0);
      rank_d[i] = RK_W'(r);
      if (alloc && tgt_oh[i]) rank_d[i] = '0;
    end
    vld_d = (vld_q & ~gone) | (alloc ? tgt_oh : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (alloc && tgt_oh[g]) begin
        line_q[g] <= op_line;
        own_q[g]  <= op_req;
      end
      if (vld_d[g]) rank_q[g] <= rank_d[g];
    end
  end

  // checks on stored state
  logic dup_line, rank_clash;
  always_comb begin
    dup_line   = 1'b0;
    rank_clash = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (vld_q[i] && vld_q[j] && (line_q[i] == line_q[j])) dup_line = 1'b1;
        if (vld_q[i] && vld_q[j] && (rank_q[i] == rank_q[j])) rank_clash = 1'b1;
      end
    end
  end

  AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_line); // R12
  AST_RANK_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    !rank_clash); // R13
  AST_SC_LINE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sc && !alloc) |=> !(|(vld_q & ~$past(vld_q)))); // R5
endmodule

// File: rtl/llsc_resv_mon.sv
module llsc_resv_mon #(
  parameter int N      = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bypass,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_op,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic [ID_W-1:0]   cmp_req,
  input  logic              cmp_present,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  input  logic [ID_W-1:0]   inv_req,
  output logic              res_valid,
  output logic              res_ok,
  output logic [LINE_W-1:0] res_line,
  output logic              q_block,
  output logic              q_unblock
);
  logic is_ll, is_sc, is_wr, is_lrd, is_lwr;
  logic op_en, inv_en, sc_hit;

  logic              vld_q, ok_q, blk_q, ublk_q;
  logic              vld_d, ok_d, blk_d, ublk_d;
  logic [LINE_W-1:0] line_q;

  llsc_op_decode u_dec (
    .op     (cmp_op),
    .is_ll  (is_ll),
    .is_sc  (is_sc),
    .is_wr  (is_wr),
    .is_lrd (is_lrd),
    .is_lwr (is_lwr)
  );

  assign op_en  = cmp_valid && cmp_present && !cfg_bypass;
  assign inv_en = inv_valid && !cfg_bypass;

  llsc_resv_table #(.N(N), .LINE_W(LINE_W), .ID_W(ID_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_en   (inv_en),
    .inv_line (inv_line),
    .inv_req  (inv_req),
    .op_en    (op_en),
    .op_ll    (is_ll),
    .op_sc    (is_sc),
    .op_wr    (is_wr),
    .op_line  (cmp_line),
    .op_req   (cmp_req),
    .sc_hit   (sc_hit)
  );

  always_comb begin
    vld_d  = cmp_valid;
    ok_d   = !(op_en && is_sc) || sc_hit;
    blk_d  = cmp_valid && is_lrd;
    ublk_d = cmp_valid && is_lwr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      blk_q  <= 1'b0;
      ublk_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      blk_q  <= blk_d;
      ublk_q <= ublk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_valid) begin
      ok_q   <= ok_d;
      line_q <= cmp_line;
    end
  end

  assign res_valid = vld_q;
  assign res_ok    = ok_q;
  assign res_line  = line_q;
  assign q_block   = blk_q;
  assign q_unblock = ublk_q;

  AST_RES_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid); // R2
  AST_NONSC_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(cmp_op) != 3'd3)) |-> res_ok); // R2
  AST_BYPASS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cfg_bypass)) |-> res_ok); // R11
  AST_BLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_block && q_unblock)); // R10
  AST_BLK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    q_block |-> $past(cmp_valid && (cmp_op == 3'd4))); // R10
endmodule

// File: tb/llsc_resv_mon_tb.sv
module llsc_resv_mon_tb_top;
  localparam int LW  = 26;
  localparam int IDW = 2;
  localparam int NE  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_bypass, cmp_valid, cmp_present, inv_valid;
  logic [2:0]     cmp_op;
  logic [LW-1:0]  cmp_line, inv_line;
  logic [IDW-1:0] cmp_req, inv_req;
  logic           res_valid, res_ok, q_block, q_unblock;
  logic [LW-1:0]  res_line;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  typedef struct {
    bit            ok;
    logic [LW-1:0] line;
    bit            blk;
    bit            ublk;
    string         tag;
  } exp_t;
  exp_t exp_q [$];

  always #5 clk = ~clk;

  llsc_resv_mon #(.N(NE), .LINE_W(LW), .ID_W(IDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass),
    .cmp_valid(cmp_valid), .cmp_op(cmp_op), .cmp_line(cmp_line),
    .cmp_req(cmp_req), .cmp_present(cmp_present),
    .inv_valid(inv_valid), .inv_line(inv_line), .inv_req(inv_req),
    .res_valid(res_valid), .res_ok(res_ok), .res_line(res_line),
    .q_block(q_block), .q_unblock(q_unblock)
  );

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected result: actual res_valid=1 expected=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (res_ok !== e.ok || res_line !== e.line ||
              q_block !== e.blk || q_unblock !== e.ublk) begin
            n_fail++;
            $display("FAIL %s: actual ok=%0b line=%0d blk=%0b ublk=%0b expected ok=%0b line=%0d blk=%0b ublk=%0b",
                     e.tag, res_ok, res_line, q_block, q_unblock,
                     e.ok, e.line, e.blk, e.ublk);
          end
        end
      end else if (q_block || q_unblock) begin
        n_chk++;
        n_fail++;
        $display("FAIL R10 pulse without completion: actual blk=%0b ublk=%0b expected 0 0",
                 q_block, q_unblock);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic op_inv(input logic [2:0] t, input int ln, input int rq,
                        input bit pres, input bit exp_ok, input string tag,
                        input bit iv, input int il, input int ir);
    exp_t e;
    @(negedge clk);
    cmp_valid   = 1'b1;
    cmp_op      = t;
    cmp_line    = LW'(ln);
    cmp_req     = IDW'(rq);
    cmp_present = pres;
    inv_valid   = iv;
    inv_line    = LW'(il);
    inv_req     = IDW'(ir);
    e.ok   = exp_ok;
    e.line = LW'(ln);
    e.blk  = (t == 3'd4);
    e.ublk = (t == 3'd5);
    e.tag  = tag;
    exp_q.push_back(e);
    @(negedge clk);
    cmp_valid = 1'b0;
    inv_valid = 1'b0;
  endtask

  task automatic op(input logic [2:0] t, input int ln, input int rq,
                    input bit pres, input bit exp_ok, input string tag);
    op_inv(t, ln, rq, pres, exp_ok, tag, 1'b0, 0, 0);
  endtask

  task automatic inv_only(input int il, input int ir);
    @(negedge clk);
    inv_valid = 1'b1;
    inv_line  = LW'(il);
    inv_req   = IDW'(ir);
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  localparam logic [2:0] LD = 3'd0, ST = 3'd1, LL = 3'd2, SC = 3'd3,
                         LRD = 3'd4, LWR = 3'd5, FL = 3'd6, IF = 3'd7;

  initial begin
    rst_n = 1'b0; cfg_bypass = 1'b0; cmp_valid = 1'b0; cmp_present = 1'b1;
    inv_valid = 1'b0; cmp_op = '0; cmp_line = '0; cmp_req = '0;
    inv_line = '0; inv_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0 || q_block !== 1'b0 || q_unblock !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: actual %0b%0b%0b expected 000",
               res_valid, q_block, q_unblock);
    end
    op(SC, 5, 0, 1, 0, "R1 empty table after reset");
    // R3 / R5
    op(LL, 5, 0, 1, 1, "R2 LL result");
    op(SC, 5, 0, 1, 1, "R3 SC by owner succeeds");
    op(SC, 5, 0, 1, 0, "R5 SC cleared reservation");
    // R4 / R5 foreign SC
    op(LL, 6, 1, 1, 1, "R3 LL");
    op(SC, 6, 2, 1, 0, "R4 SC by other requester fails");
    op(SC, 6, 1, 1, 0, "R5 failed SC still cleared lock");
    // R6
    op(LL, 7, 1, 1, 1, "R6 LL");
    op(ST, 7, 2, 1, 1, "R6 foreign store");
    op(SC, 7, 1, 1, 1, "R6 foreign store kept lock");
    op(LL, 7, 1, 1, 1, "R6 LL");
    op(ST, 7, 1, 1, 1, "R6 own store");
    op(SC, 7, 1, 1, 0, "R6 own store cleared lock");
    op(LL, 7, 1, 1, 1, "R6 LL");
    op(LRD, 7, 1, 1, 1, "R10 locked read blocks");
    op(SC, 7, 1, 1, 0, "R6 locked read cleared lock");
    op(LL, 7, 1, 1, 1, "R6 LL");
    op(FL, 7, 1, 1, 1, "R6 own flush");
    op(SC, 7, 1, 1, 0, "R6 flush cleared lock");
    op(LL, 7, 1, 1, 1, "R6 LL");
    op(LWR, 7, 1, 1, 1, "R10 locked write unblocks");
    op(SC, 7, 1, 1, 0, "R6 locked write cleared lock");
    // R7
    op(LL, 8, 0, 1, 1, "R7 LL");
    op(LD, 8, 0, 1, 1, "R7 load");
    op(IF, 8, 0, 1, 1, "R7 fetch");
    op(SC, 8, 0, 1, 1, "R7 reads left lock");
    // R8
    op(LL, 9, 0, 0, 1, "R8 absent LL");
    op(SC, 9, 0, 1, 0, "R8 absent LL set nothing");
    op(LL, 9, 0, 1, 1, "R8 LL");
    op(SC, 9, 0, 0, 1, "R8 absent SC succeeds");
    op(SC, 9, 0, 1, 1, "R8 absent SC kept lock");
    // R9
    op(LL, 10, 3, 1, 1, "R9 LL");
    inv_only(10, 2);
    op(SC, 10, 3, 1, 1, "R9 foreign invalidation ignored");
    op(LL, 10, 3, 1, 1, "R9 LL");
    inv_only(10, 3);
    op(SC, 10, 3, 1, 0, "R9 invalidation cleared lock");
    op(LL, 10, 3, 1, 1, "R9 LL");
    op_inv(SC, 10, 3, 1, 0, "R9 same-cycle invalidation first", 1'b1, 10, 3);
    // R10 absent and bypass
    op(LRD, 11, 0, 0, 1, "R10 block when absent");
    cfg_bypass = 1'b1;
    op(LWR, 11, 0, 1, 1, "R10 unblock under bypass");
    cfg_bypass = 1'b0;
    // R11
    op(LL, 12, 0, 1, 1, "R11 LL");
    cfg_bypass = 1'b1;
    op(SC, 12, 1, 1, 1, "R11 bypass SC succeeds");
    op(ST, 12, 0, 1, 1, "R11 bypass store");
    inv_only(12, 0);
    op(LL, 13, 0, 1, 1, "R11 bypass LL");
    cfg_bypass = 1'b0;
    op(SC, 12, 0, 1, 1, "R11 lock untouched in bypass");
    op(SC, 13, 0, 1, 0, "R11 bypass LL set nothing");
    // R12
    do_reset();
    op(LL, 30, 0, 1, 1, "R12 LL");
    op(LL, 30, 1, 1, 1, "R12 LL same line");
    op(LL, 31, 0, 1, 1, "R12 LL");
    op(LL, 32, 0, 1, 1, "R12 LL");
    op(LL, 33, 0, 1, 1, "R12 LL");
    op(SC, 30, 1, 1, 1, "R12 owner handed over, single entry");
    op(SC, 31, 0, 1, 1, "R12 no spurious eviction");
    // R13
    do_reset();
    for (int k = 20; k < 24; k++) op(LL, k, 0, 1, 1, "R13 fill");
    op(LL, 24, 0, 1, 1, "R13 LL when full");
    op(SC, 20, 0, 1, 0, "R13 oldest evicted");
    op(SC, 21, 0, 1, 1, "R13 second kept");
    op(LL, 22, 0, 1, 1, "R13 refresh");
    op(LL, 25, 0, 1, 1, "R13 fill free slot");
    op(LL, 26, 0, 1, 1, "R13 LL when full again");
    op(SC, 23, 0, 1, 0, "R13 oldest after refresh evicted");
    op(SC, 24, 0, 1, 1, "R13 kept 24");
    op(SC, 22, 0, 1, 1, "R13 refreshed kept");
    op(SC, 25, 0, 1, 1, "R13 kept 25");
    op(SC, 26, 0, 1, 1, "R13 kept 26");
    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing results: actual pending=%0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule